// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C master. A programmable prescaler divides the functional clock down to an internal tick. Two count words then set how many ticks SCL is held low and how many ticks it is left released. Each count word carries two byte-wide values: the low byte serves standard and fast transfers, and the high byte serves high-speed transfers. The `hs_mode` input picks which byte is used. For a high-speed transfer the surrounding sequencer keeps `hs_mode` low while the opening phase runs at fast-mode rate, then raises it. A typical software setup for a 100 kHz bus comes from the same arithmetic: the tick rate divided by twice the bus rate, minus the fixed offset.

The generator also marks where SDA may change and where SDA is to be sampled. It does this with one-cycle strobes placed in the middle of the low and high phases. After it releases SCL, the generator waits until the line is sensed high before it times the high phase. A slave that holds SCL low therefore stretches the clock.

A small state machine drives the block. Its states are IDLE, LOW, WAIT_HI and HIGH. A tick while enabled moves IDLE to LOW (start). LOW moves to WAIT_HI when the low count expires (release). WAIT_HI moves to HIGH on a tick that sees SCL high (line up). HIGH moves to LOW when the high count expires (pull). Clearing the enable sends any state to IDLE on the next edge (abort).

Top module: `scl_timegen`

## Requirements
- R1: After reset, and in the cycle after `en` is sampled low, `scl_drive_low` is 0 and neither strobe is asserted.
- R2: With prescaler value P, internal ticks occur every P+1 clock cycles while enabled; `en` held low keeps the prescaler at its restart point.
- R3: The low phase lasts exactly (Lc+6)*(P+1) clock cycles, where Lc is the selected byte of `low_cfg`.
- R4: With SCL returning high at once, the released phase lasts exactly (Hc+6)*(P+1) clock cycles, where Hc is the selected byte of `high_cfg`.
- R5: `hs_mode`=0 selects bits 7:0 of both count words, and `hs_mode`=1 selects bits 15:8.
- R6: `sda_drive_stb` pulses exactly once per low phase, for one cycle, in low-phase cycle ((L>>1)+1)*(P+1), counted from 1, where L=Lc+6. It is only ever asserted while SCL is driven low.
- R7: `sda_sample_stb` pulses exactly once per high phase, in released cycle ((H>>1)+1)*(P+1), counted from 1, where H=Hc+6. It is only ever asserted while SCL is released and sensed high.
- R8: While SCL is released but sensed low, the high phase does not advance, no sample strobe is produced and SCL stays released. Timing of the high phase starts at the first tick that sees the line high.
- R9: A change of the prescaler value restarts the divider in the cycle the change is seen, and later ticks follow the new period.
- R10: Clearing `en` in the middle of a phase releases SCL in the next cycle.
- R11: After `en` is raised from idle, SCL is first driven low in the (P+1)-th cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable; low forces IDLE with SCL released |
| hs_mode | input | 1 | Selects the high-speed byte (1) or the fast/standard byte (0) |
| prescale | input | 8 | Prescaler value P; tick period is P+1 cycles |
| low_cfg | input | 16 | Low-phase counts: [7:0] fast/standard, [15:8] high-speed |
| high_cfg | input | 16 | High-phase counts: [7:0] fast/standard, [15:8] high-speed |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_drive_stb | output | 1 | One-cycle strobe at mid low phase for changing SDA |
| sda_sample_stb | output | 1 | One-cycle strobe at mid high phase for sampling SDA |

## Verification
The bench sweeps prescaler values 0 to 3 against several count values in both byte selections, including a count near the byte maximum. For each setting it measures the exact start latency, the low and released lengths, and the strobe positions. A design with an off-by-one offset, a swapped byte select, or a prescaler that divides by P instead of P+1 shows up as a cycle-count mismatch. The stretch case holds SCL low after release, and the bench expects the high phase to be timed only from the release. A design that counted during the stretch would pull SCL low too early, or strobe while the line was low. The prescaler rewrite lands mid-phase, and the bench expects the remainder of the phase at the new period from the change onward. A divider that kept its old count would end the phase one or more cycles late. The bench also drops the enable in the middle of a low phase and expects SCL released on the next cycle.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
    typedef enum logic [1:0] {
        SG_IDLE    = 2'd0,
        SG_LOW     = 2'd1,
        SG_WAIT_HI = 2'd2,
        SG_HIGH    = 2'd3
    } sg_state_e;
endpackage

// File: rtl/sclg_prescaler.sv
module sclg_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pc;
    logic [W-1:0] div_q;
    logic         div_changed;

    assign div_changed = (div != div_q);
    assign tick        = run && !div_changed && (pc == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            div_q <= '0;
        end else begin
            div_q <= div;
            if (!run || div_changed || pc >= div)
                pc <= '0;
            else
                pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/sclg_count_pick.sv
module sclg_count_pick #(
    parameter int CNT_W  = 8,
    parameter int OFFSET = 6,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic [2*CNT_W-1:0] word,
    input  logic               hs,
    output logic [LEN_W-1:0]   len,
    output logic [LEN_W-1:0]   half
);
    logic [CNT_W-1:0] sel;

    always_comb begin
        sel  = hs ? word[2*CNT_W-1:CNT_W] : word[CNT_W-1:0];
        len  = LEN_W'(sel) + LEN_W'(OFFSET);
        half = len >> 1;
    end
endmodule

// File: rtl/scl_timegen.sv
module scl_timegen #(
    parameter int PSC_W  = 8,
    parameter int CNT_W  = 8,
    parameter int OFFSET = 6,
    localparam int PH_W  = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               hs_mode,
    input  logic [PSC_W-1:0]   prescale,
    input  logic [2*CNT_W-1:0] low_cfg,
    input  logic [2*CNT_W-1:0] high_cfg,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               sda_drive_stb,
    output logic               sda_sample_stb
);
    import sclg_pkg::*;

    sg_state_e       state, state_nxt;
    logic [PH_W-1:0] cnt, cnt_nxt;
    logic [PH_W-1:0] low_len, low_half, high_len, high_half;
    logic            tick;

    sclg_prescaler #(.W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en),
        .div   (prescale),
        .tick  (tick)
    );

    sclg_count_pick #(.CNT_W(CNT_W), .OFFSET(OFFSET)) u_low_pick (
        .word (low_cfg),
        .hs   (hs_mode),
        .len  (low_len),
        .half (low_half)
    );

    sclg_count_pick #(.CNT_W(CNT_W), .OFFSET(OFFSET)) u_high_pick (
        .word (high_cfg),
        .hs   (hs_mode),
        .len  (high_len),
        .half (high_half)
    );

    // Next-state logic: phases advance only on prescaler ticks
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            SG_IDLE: begin
                if (tick) begin
                    state_nxt = SG_LOW;
                    cnt_nxt   = '0;
                end
            end
            SG_LOW: begin
                if (tick) begin
                    if (cnt >= low_len - 1'b1) begin
                        state_nxt = SG_WAIT_HI;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            SG_WAIT_HI: begin
                // the tick that sees the line high is the first high tick
                if (tick && scl_in) begin
                    state_nxt = SG_HIGH;
                    cnt_nxt   = PH_W'(1);
                end
            end
            SG_HIGH: begin
                if (tick) begin
                    if (cnt >= high_len - 1'b1) begin
                        state_nxt = SG_LOW;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
        endcase
        if (!en) begin
            state_nxt = SG_IDLE;
            cnt_nxt   = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SG_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Outputs
    always_comb begin
        scl_drive_low  = (state == SG_LOW);
        sda_drive_stb  = (state == SG_LOW)  && tick && (cnt == low_half);
        sda_sample_stb = (state == SG_HIGH) && tick && (cnt == high_half);
    end
endmodule

// File: rtl/sclg_chk.sv
module sclg_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_drive_stb,
    input logic sda_sample_stb
);
    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_release_chk: assert (!scl_drive_low && !sda_drive_stb && !sda_sample_stb);
        end
    end

    // R10
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_drive_low && !sda_drive_stb && !sda_sample_stb));

    // R6
    drive_stb_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_stb |-> scl_drive_low);

    // R7
    sample_stb_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample_stb |-> (!scl_drive_low && scl_in));

    // R8
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !scl_drive_low && !scl_in) |-> !sda_sample_stb);

    // R11
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> $past(en));
endmodule

bind scl_timegen sclg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .scl_in         (scl_in),
    .scl_drive_low  (scl_drive_low),
    .sda_drive_stb  (sda_drive_stb),
    .sda_sample_stb (sda_sample_stb)
);

// File: tb/scl_timegen_bench.sv
module scl_timegen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        hs_mode = 1'b0;
    logic [7:0]  prescale = 8'd0;
    logic [15:0] low_cfg = 16'd0;
    logic [15:0] high_cfg = 16'd0;
    logic        hold_low = 1'b0;
    logic        scl_in;
    logic        scl_drive_low, sda_drive_stb, sda_sample_stb;
    int          checks = 0;
    int          fails = 0;

    assign scl_in = !(scl_drive_low || hold_low);

    always #2 clk = ~clk;

    scl_timegen u_scl_timegen (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .hs_mode        (hs_mode),
        .prescale       (prescale),
        .low_cfg        (low_cfg),
        .high_cfg       (high_cfg),
        .scl_in         (scl_in),
        .scl_drive_low  (scl_drive_low),
        .sda_drive_stb  (sda_drive_stb),
        .sda_sample_stb (sda_sample_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cfg(input int p, input int lc, input int hc, input bit hs);
        int t, l, h, n, lowc, dpos, dcnt, hic, spos, scnt;
        t = p + 1;
        l = (hs ? lc + 2 : lc) + 6;
        h = (hs ? hc + 1 : hc) + 6;
        en = 1'b0;
        prescale = 8'(p);
        low_cfg = {8'(lc + 2), 8'(lc)};
        high_cfg = {8'(hc + 1), 8'(hc)};
        hs_mode = hs;
        repeat (3) @(negedge clk);
        en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!scl_drive_low && n < 2000);
        chk(n == t, "R11 start latency", n, t);
        lowc = 0; dpos = -1; dcnt = 0;
        while (scl_drive_low && lowc < 5000) begin
            lowc++;
            if (sda_drive_stb) begin dcnt++; dpos = lowc; end
            @(negedge clk);
        end
        // R3 / R5 / R2: low length depends on selected byte and tick period
        chk(lowc == l * t, hs ? "R3 R5 low length hs" : "R3 R2 low length fs", lowc, l * t);
        chk(dcnt == 1, "R6 drive strobe count", dcnt, 1);
        chk(dpos == ((l >> 1) + 1) * t, "R6 drive strobe position", dpos, ((l >> 1) + 1) * t);
        hic = 0; spos = -1; scnt = 0;
        while (!scl_drive_low && hic < 5000) begin
            hic++;
            if (sda_sample_stb) begin scnt++; spos = hic; end
            @(negedge clk);
        end
        chk(hic == h * t, hs ? "R4 R5 high length hs" : "R4 high length fs", hic, h * t);
        chk(scnt == 1, "R7 sample strobe count", scnt, 1);
        chk(spos == ((h >> 1) + 1) * t, "R7 sample strobe position", spos, ((h >> 1) + 1) * t);
        // R10: drop enable in the first cycle of the next low phase
        en = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low && !sda_drive_stb && !sda_sample_stb, "R10 disable releases",
            int'(scl_drive_low), 0);
    endtask

    initial begin
        int n, bad;
        repeat (3) @(negedge clk);
        bad = 0;
        repeat (4) begin
            if (scl_drive_low || sda_drive_stb || sda_sample_stb) bad++;
            @(negedge clk);
        end
        rst_n = 1'b1;
        repeat (6) begin
            if (scl_drive_low || sda_drive_stb || sda_sample_stb) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R1 reset and idle released", bad, 0);

        for (int p = 0; p < 4; p++)
            for (int li = 0; li < 2; li++)
                for (int hi = 0; hi < 2; hi++)
                    for (int hs = 0; hs < 2; hs++)
                        run_cfg(p, li * 3, hi * 2, hs[0]);
        run_cfg(1, 250, 249, 1'b1);
        run_cfg(0, 251, 3, 1'b0);

        // R8: clock stretch, P=1, L=H=6
        prescale = 8'd1; low_cfg = 16'd0; high_cfg = 16'd0; hs_mode = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        n = 0;
        while (!scl_drive_low && n < 2000) begin @(negedge clk); n++; end
        while (scl_drive_low && n < 4000) begin @(negedge clk); n++; end
        hold_low = 1'b1;
        bad = 0;
        repeat (20) begin
            if (scl_drive_low || sda_sample_stb) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R8 no progress while stretched", bad, 0);
        hold_low = 1'b0;
        n = 0;
        while (!scl_drive_low && n < 2000) begin n++; @(negedge clk); end
        chk(n == 12, "R8 high timed after release", n, 12);
        en = 1'b0;
        repeat (2) @(negedge clk);

        // R9: prescaler rewrite mid low phase, 5 -> 1, L=6
        prescale = 8'd5;
        repeat (3) @(negedge clk);
        en = 1'b1;
        n = 0;
        while (!scl_drive_low && n < 2000) begin @(negedge clk); n++; end
        n = 0;
        while (scl_drive_low && n < 2000) begin
            n++;
            if (n == 3) prescale = 8'd1;
            @(negedge clk);
        end
        chk(n == 15, "R9 prescaler restart on rewrite", n, 15);
        en = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule